// File: doc/BRIEF.md
# SPI Memory Pointer Command Engine

This block is the command front end of an SPI slave that reaches a word-wide internal RAM through a small bank of address pointers. Each chip-select frame begins with a one-byte opcode. A two-bit field in a configuration word picks the pointer that the opcode works on. The field is sampled once, when the frame opens. Three opcodes only move the selected pointer forward by 1, 2 or 4. Three opcodes move data. A read fetches the word at the pointer and shifts it out MSB first. A write shifts a word in and stores it at the pointer. A third data opcode bumps the pointer by one before it starts writing.

Once a read or write has started, it keeps going word by word as long as chip select stays low, and the pointer steps by one after each complete word. One frame carries exactly one command. Any opcode outside the supported set does nothing until chip select rises. This includes the fast register-access opcodes that another path serves. SPI runs in mode 0 and is oversampled by the system clock. The memory side is a registered request port with a fixed read latency.

Top module: `spi_map_engine`

## Requirements
- R1: After reset every pointer is zero, no memory request is active, and MISO is low. MISO also returns low whenever chip select is high.
- R2: Bits 11:10 of `cfg_word` select the active pointer. The value is captured when chip select falls, so changing it later in the same frame has no effect on that frame.
- R3: Opcodes 0xD0, 0xD2 and 0xD4 add 1, 2 and 4 to the active pointer. They leave the other pointers alone and make no memory request.
- R4: Pointer arithmetic wraps modulo 2^ADDR_W.
- R5: Opcode 0x40 reads the word at the active pointer's current value. The pointer is not changed first. The word appears on MISO MSB first, with a new bit after each falling SCLK edge.
- R6: During a read, each word fully clocked out advances the pointer by one, and the next word comes from the following address. A word cut short by chip select rising does not advance the pointer.
- R7: Opcode 0xC0 stores each received 16-bit word (MSB first, sampled on rising SCLK) at the active pointer, then advances the pointer by one. One memory write pulse is issued per word.
- R8: Opcode 0xC8 adds 1 to the active pointer before the first data word, then behaves like 0xC0.
- R9: A write word with fewer than 16 bits when chip select rises is discarded. It produces no memory write and no pointer change.
- R10: Commands do not chain. After a pointer-add opcode, further SCLK cycles in the same frame have no effect, even if they carry opcode patterns.
- R11: Any other opcode value is ignored until chip select rises. It changes no pointer and makes no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also used to oversample SPI |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | CFG_W | Configuration word; bits SEL_LSB+1:SEL_LSB select the pointer |
| spi_sclk | input | 1 | SPI serial clock (mode 0) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from host |
| spi_miso | output | 1 | SPI data to host |
| mem_addr | output | ADDR_W | Memory request address |
| mem_rd | output | 1 | One-cycle read request |
| mem_wr | output | 1 | One-cycle write request |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid RD_LAT cycles after `mem_rd` |

## Verification
The read and write paths are tried with bursts of one to three words and with trailing partial words. Comparing pointer values after these frames separates a correct per-word advance from advancing on the opcode or on partial bits. Pointer-add, unsupported and fast-access opcodes are sent with extra clocks that carry valid opcode bytes, which shows whether the engine drains the frame or decodes a second command. A select change inside a frame distinguishes latching at frame start from tracking the live field. Repeated adds near the top of the address range expose any failure to wrap.

// File: rtl/spi_map_pkg.sv
package spi_map_pkg;

   localparam int OPC_W = 8;

   // supported command bytes
   localparam logic [OPC_W-1:0] OPC_READ    = 8'h40;
   localparam logic [OPC_W-1:0] OPC_WRITE   = 8'hC0;
   localparam logic [OPC_W-1:0] OPC_BUMP_WR = 8'hC8;
   localparam logic [OPC_W-1:0] OPC_ADD1    = 8'hD0;
   localparam logic [OPC_W-1:0] OPC_ADD2    = 8'hD2;
   localparam logic [OPC_W-1:0] OPC_ADD4    = 8'hD4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPC,
      ST_RD,
      ST_WR,
      ST_DRAIN
   } map_state_t;

endpackage

// File: rtl/spi_map_sync.sv
module spi_map_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic cs_n_i,
   input  logic mosi_i,
   output logic sclk_rise,
   output logic sclk_fall,
   output logic cs_n_s,
   output logic mosi_s
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_map_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sclk_p;
   logic [STAGES-1:0] cs_p;
   logic [STAGES-1:0] mosi_p;
   logic              sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_p <= '0;
         cs_p   <= '1;
         mosi_p <= '0;
         sclk_d <= 1'b0;
      end else begin
         sclk_p <= {sclk_p[STAGES-2:0], sclk_i};
         cs_p   <= {cs_p[STAGES-2:0], cs_n_i};
         mosi_p <= {mosi_p[STAGES-2:0], mosi_i};
         sclk_d <= sclk_p[STAGES-1];
      end
   end

   assign sclk_rise = sclk_p[STAGES-1] & ~sclk_d;
   assign sclk_fall = ~sclk_p[STAGES-1] & sclk_d;
   assign cs_n_s    = cs_p[STAGES-1];
   assign mosi_s    = mosi_p[STAGES-1];

endmodule

// File: rtl/spi_map_ptr_bank.sv
module spi_map_ptr_bank #(
   parameter int ADDR_W = 10,
   parameter int SEL_W  = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [SEL_W-1:0]              sel,
   input  logic                          inc_en,
   input  logic [2:0]                    inc_amt,
   output logic [ADDR_W-1:0]             ptr_act,
   output logic [(1<<SEL_W)*ADDR_W-1:0]  ptr_flat
);

   localparam int NPTR = 1 << SEL_W;

   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $error("spi_map_ptr_bank: ADDR_W must be at least 3");
      end
   endgenerate

   logic [ADDR_W-1:0] ptr_q [NPTR];

   generate
      for (genvar g = 0; g < NPTR; g++) begin : g_ptr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ptr_q[g] <= '0;
            end else if (inc_en && (sel == SEL_W'(g))) begin
               ptr_q[g] <= ptr_q[g] + ADDR_W'(inc_amt);
            end
         end
         assign ptr_flat[g*ADDR_W +: ADDR_W] = ptr_q[g];
      end
   endgenerate

   assign ptr_act = ptr_q[sel];

endmodule

// File: rtl/spi_map_engine.sv
module spi_map_engine
   import spi_map_pkg::*;
#(
   parameter int ADDR_W      = 10,
   parameter int DATA_W      = 16,
   parameter int CFG_W       = 16,
   parameter int SEL_LSB     = 10,
   parameter int SEL_W       = 2,
   parameter int SYNC_STAGES = 2,
   parameter int RD_LAT      = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CFG_W-1:0]  cfg_word,
   input  logic              spi_sclk,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);

   localparam int CNT_W = $clog2(DATA_W);
   localparam int NPTR  = 1 << SEL_W;
   localparam logic [CNT_W-1:0] OPC_LAST  = CNT_W'(OPC_W - 1);
   localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(DATA_W - 1);

   generate
      if (DATA_W < OPC_W || DATA_W != (1 << CNT_W)) begin : g_bad_data
         $error("spi_map_engine: DATA_W must be a power of two no smaller than 8");
      end
      if (SEL_LSB + SEL_W > CFG_W) begin : g_bad_sel
         $error("spi_map_engine: select field lies outside cfg_word");
      end
      if (RD_LAT < 1) begin : g_bad_lat
         $error("spi_map_engine: RD_LAT must be at least 1");
      end
   endgenerate

   // synchronised SPI view
   logic sclk_rise, sclk_fall, cs_n_s, mosi_s;

   spi_map_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk_i   (spi_sclk),
      .cs_n_i   (spi_cs_n),
      .mosi_i   (spi_mosi),
      .sclk_rise(sclk_rise),
      .sclk_fall(sclk_fall),
      .cs_n_s   (cs_n_s),
      .mosi_s   (mosi_s)
   );

   map_state_t             state;
   logic [SEL_W-1:0]       sel_q;
   logic [OPC_W-2:0]       op_sh;
   logic [CNT_W-1:0]       bitcnt;
   logic [DATA_W-1:0]      rx_sh;
   logic [DATA_W-1:0]      tx_sh;
   logic                   rd_valid;
   logic                   inc_en;
   logic [2:0]             inc_amt;
   logic [ADDR_W-1:0]      ptr_act;
   logic [NPTR*ADDR_W-1:0] ptr_flat;

   logic [OPC_W-1:0]  opc_byte;
   logic [DATA_W-1:0] rx_word;
   logic              op_done;
   logic              word_done;

   assign opc_byte  = {op_sh, mosi_s};
   assign rx_word   = {rx_sh[DATA_W-2:0], mosi_s};
   assign op_done   = (state == ST_OPC) && sclk_rise && (bitcnt == OPC_LAST);
   assign word_done = sclk_rise && (bitcnt == WORD_LAST);

   spi_map_ptr_bank #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_ptrs (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel_q),
      .inc_en  (inc_en),
      .inc_amt (inc_amt),
      .ptr_act (ptr_act),
      .ptr_flat(ptr_flat)
   );

   // pointer update request
   always_comb begin
      inc_en  = 1'b0;
      inc_amt = 3'd0;
      if (!cs_n_s) begin
         if (op_done) begin
            case (opc_byte)
               OPC_ADD1, OPC_BUMP_WR: begin inc_en = 1'b1; inc_amt = 3'd1; end
               OPC_ADD2:              begin inc_en = 1'b1; inc_amt = 3'd2; end
               OPC_ADD4:              begin inc_en = 1'b1; inc_amt = 3'd4; end
               default:               ;
            endcase
         end else if ((state == ST_RD || state == ST_WR) && word_done) begin
            inc_en  = 1'b1;
            inc_amt = 3'd1;
         end
      end
   end

   // frame sequencer and memory requests
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         sel_q     <= '0;
         op_sh     <= '0;
         bitcnt    <= '0;
         rx_sh     <= '0;
         mem_addr  <= '0;
         mem_rd    <= 1'b0;
         mem_wr    <= 1'b0;
         mem_wdata <= '0;
      end else begin
         mem_rd <= 1'b0;
         mem_wr <= 1'b0;
         if (cs_n_s) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
         end else begin
            case (state)
               ST_IDLE: begin
                  state  <= ST_OPC;
                  bitcnt <= '0;
                  sel_q  <= cfg_word[SEL_LSB +: SEL_W];
               end
               ST_OPC: begin
                  if (sclk_rise) begin
                     op_sh  <= opc_byte[OPC_W-2:0];
                     bitcnt <= bitcnt + CNT_W'(1);
                     if (bitcnt == OPC_LAST) begin
                        bitcnt <= '0;
                        case (opc_byte)
                           OPC_READ: begin
                              state    <= ST_RD;
                              mem_addr <= ptr_act;
                              mem_rd   <= 1'b1;
                           end
                           OPC_WRITE, OPC_BUMP_WR: state <= ST_WR;
                           default:                state <= ST_DRAIN;
                        endcase
                     end
                  end
               end
               ST_RD: begin
                  if (sclk_rise) begin
                     bitcnt <= bitcnt + CNT_W'(1);
                     if (word_done) begin
                        mem_addr <= ptr_act + ADDR_W'(1);
                        mem_rd   <= 1'b1;
                     end
                  end
               end
               ST_WR: begin
                  if (sclk_rise) begin
                     rx_sh  <= rx_word;
                     bitcnt <= bitcnt + CNT_W'(1);
                     if (word_done) begin
                        mem_addr  <= ptr_act;
                        mem_wdata <= rx_word;
                        mem_wr    <= 1'b1;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // read-data valid, delayed to match the memory latency
   generate
      if (RD_LAT == 1) begin : g_lat1
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_valid <= 1'b0;
            else        rd_valid <= mem_rd;
         end
      end else begin : g_latn
         logic [RD_LAT-1:0] rd_pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_pipe <= '0;
            else        rd_pipe <= {rd_pipe[RD_LAT-2:0], mem_rd};
         end
         assign rd_valid = rd_pipe[RD_LAT-1];
      end
   endgenerate

   // outbound shifter: load on data return, shift on falling SCLK inside a word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh <= '0;
      end else if (cs_n_s) begin
         tx_sh <= '0;
      end else if (rd_valid) begin
         tx_sh <= mem_rdata;
      end else if (state == ST_RD && sclk_fall && bitcnt != '0) begin
         tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
      end
   end

   assign spi_miso = tx_sh[DATA_W-1];

endmodule

// File: rtl/spi_map_engine_chk.sv
module spi_map_engine_chk
   import spi_map_pkg::*;
#(
   parameter int PF_W = 40
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cs_n_s,
   input map_state_t      state,
   input logic            mem_rd,
   input logic            mem_wr,
   input logic [PF_W-1:0] ptr_flat,
   input logic            spi_miso
);

   // R11
   ptr_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_IDLE) |-> $stable(ptr_flat));

   // R3
   drain_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DRAIN) |-> (!mem_rd && !mem_wr));

   // R7
   wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> !mem_wr);

   // R9
   wr_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> !$past(cs_n_s));

   // R1
   miso_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |=> !spi_miso);

   // R5
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

endmodule

bind spi_map_engine spi_map_engine_chk #(.PF_W((1 << SEL_W) * ADDR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cs_n_s  (cs_n_s),
   .state   (state),
   .mem_rd  (mem_rd),
   .mem_wr  (mem_wr),
   .ptr_flat(ptr_flat),
   .spi_miso(spi_miso)
);

// File: tb/spi_map_engine_tb.sv
`timescale 1ns/1ps
module spi_map_engine_tb;

   localparam int AW    = 6;
   localparam int DEPTH = 1 << AW;
   localparam int MASK  = DEPTH - 1;
   localparam int HALF  = 8;
   localparam int GAP   = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cfg_word = 16'h0000;
   logic        spi_sclk = 1'b0;
   logic        spi_cs_n = 1'b1;
   logic        spi_mosi = 1'b0;
   logic        spi_miso;
   logic [AW-1:0] mem_addr;
   logic        mem_rd, mem_wr;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = 16'h0;

   always #2 clk = ~clk;

   spi_map_engine #(.ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
      .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   function automatic logic [15:0] init_word(int i);
      return 16'((i * 12059) ^ 23100);
   endfunction

   // bench memory with one-cycle read latency
   logic [15:0] bmem [DEPTH];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) bmem[i] <= init_word(i);
      end else begin
         if (mem_wr) bmem[mem_addr] <= mem_wdata;
         if (mem_rd) mem_rdata <= bmem[mem_addr];
      end
   end

   // request monitor
   int rd_n = 0, wr_n = 0;
   int rd_log [1024];
   always @(posedge clk) begin
      if (rst_n) begin
         if (mem_rd) begin rd_log[rd_n % 1024] = int'(mem_addr); rd_n++; end
         if (mem_wr) wr_n++;
      end
   end

   int n_chk = 0, n_err = 0;
   bit done = 0;
   int mptr [4];
   logic [15:0] mmem [DEPTH];
   logic [15:0] wbuf [4];
   logic [15:0] rbuf [4];
   logic [31:0] xpat = 32'hD4C0_40D0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic xfer_bit(input logic b, output logic r);
      spi_mosi = b;
      tick(HALF);
      r = spi_miso;
      spi_sclk = 1'b1;
      tick(HALF);
      spi_sclk = 1'b0;
   endtask

   task automatic frame(input logic [7:0] op, input int nw, input int extra,
                        input int sel, input int sw_at);
      logic r;
      cfg_word = 16'h0123 | 16'(sel << 10);
      spi_cs_n = 1'b0;
      tick(HALF);
      for (int i = 0; i < 8; i++) begin
         if (i == sw_at) cfg_word = 16'h0123 | 16'((sel ^ 3) << 10);
         xfer_bit(op[7-i], r);
      end
      for (int w = 0; w < nw; w++)
         for (int b = 0; b < 16; b++) begin
            xfer_bit(wbuf[w][15-b], r);
            rbuf[w][15-b] = r;
         end
      for (int i = 0; i < extra; i++) xfer_bit(xpat[31 - (i % 32)], r);
      tick(HALF);
      spi_cs_n = 1'b1;
      tick(GAP);
   endtask

   // pointer observation: a read opcode with no full word shows the pointer on mem_addr
   task automatic probe(input int sel, input string req);
      int r0;
      r0 = rd_n;
      frame(8'h40, 0, 4, sel, -1);
      chk(rd_n == r0 + 1, req, rd_n - r0, 1);
      chk(rd_log[r0 % 1024] == mptr[sel], req, rd_log[r0 % 1024], mptr[sel]);
   endtask

   task automatic probe_all(input string req);
      for (int s = 0; s < 4; s++) probe(s, req);
   endtask

   function automatic bit is_cmd(logic [7:0] op);
      return op == 8'h40 || op == 8'hC0 || op == 8'hC8 ||
             op == 8'hD0 || op == 8'hD2 || op == 8'hD4;
   endfunction

   // run a frame and check it against the model
   task automatic run(input logic [7:0] op, input int nw, input int extra, input int sel);
      int r0, w0;
      r0 = rd_n; w0 = wr_n;
      for (int w = 0; w < 4; w++) wbuf[w] = 16'($urandom);
      frame(op, nw, extra, sel, -1);
      case (op)
         8'hD0, 8'hD2, 8'hD4: begin
            mptr[sel] = (mptr[sel] + ((op == 8'hD0) ? 1 : (op == 8'hD2) ? 2 : 4)) & MASK;
            chk(rd_n == r0 && wr_n == w0, "R3 no memory access on add", rd_n + wr_n, r0 + w0);
         end
         8'h40: begin
            for (int w = 0; w < nw; w++) begin
               chk(rbuf[w] == mmem[mptr[sel]], (w == 0) ? "R5 read word" : "R6 burst word",
                   rbuf[w], mmem[mptr[sel]]);
               mptr[sel] = (mptr[sel] + 1) & MASK;
            end
            chk(wr_n == w0, "R5 read makes no write", wr_n - w0, 0);
         end
         8'hC0, 8'hC8: begin
            if (op == 8'hC8) mptr[sel] = (mptr[sel] + 1) & MASK;
            for (int w = 0; w < nw; w++) begin
               mmem[mptr[sel]] = wbuf[w];
               mptr[sel] = (mptr[sel] + 1) & MASK;
            end
            chk(wr_n - w0 == nw, (extra > 0) ? "R9 partial word dropped" : "R7 write count",
                wr_n - w0, nw);
         end
         default: chk(rd_n == r0 && wr_n == w0, "R11 ignored opcode", rd_n + wr_n, r0 + w0);
      endcase
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [7:0] rop;
      void'($urandom(32'h5eed_1553));
      for (int i = 0; i < 4; i++) mptr[i] = 0;
      for (int i = 0; i < DEPTH; i++) mmem[i] = init_word(i);
      tick(5);
      rst_n = 1'b1;
      tick(5);

      // R1 reset state
      chk(spi_miso == 1'b0, "R1 miso after reset", spi_miso, 0);
      chk(mem_rd == 1'b0 && mem_wr == 1'b0, "R1 no request after reset", {mem_rd, mem_wr}, 0);
      probe_all("R1 pointers zero");

      // R3 adds on distinct pointers
      run(8'hD0, 0, 0, 0);
      run(8'hD2, 0, 0, 1);
      run(8'hD4, 0, 0, 2);
      run(8'hD4, 0, 0, 3);
      run(8'hD4, 0, 0, 3);
      probe_all("R3 add amounts per pointer");

      // R4 wrap: bring pointer 3 to 62, then add 4
      run(8'hD2, 0, 0, 3);
      for (int i = 0; i < 13; i++) run(8'hD4, 0, 0, 3);
      probe(3, "R4 pointer at 62");
      run(8'hD4, 0, 0, 3);
      probe(3, "R4 wrap to 2");

      // R5, R6 read bursts
      run(8'h40, 3, 0, 0);
      probe(0, "R6 pointer after 3-word read");
      run(8'h40, 1, 7, 0);
      probe(0, "R6 partial read word no advance");

      // R7, R8, R9 writes
      run(8'hC0, 2, 0, 1);
      probe(1, "R7 pointer after 2-word write");
      run(8'hC8, 1, 0, 2);
      probe(2, "R8 pre-increment write");
      run(8'hC0, 1, 9, 1);
      probe(1, "R9 pointer after partial write");
      run(8'h40, 2, 0, 2);
      probe(2, "R8 read back after write");

      // R10 no chaining after add
      wbuf[0] = 16'hD4D4; wbuf[1] = 16'h40C0;
      begin
         int r0, w0;
         r0 = rd_n; w0 = wr_n;
         frame(8'hD2, 2, 0, 0, -1);
         mptr[0] = (mptr[0] + 2) & MASK;
         chk(rd_n == r0 && wr_n == w0, "R10 trailing bytes no access", rd_n + wr_n, r0 + w0);
      end
      probe_all("R10 only first opcode acts");

      // R11 unsupported / fast-access opcodes
      run(8'h00, 1, 0, 1);
      run(8'h41, 2, 0, 2);
      run(8'hFF, 1, 5, 3);
      run(8'h82, 1, 0, 0);
      probe_all("R11 pointers unchanged");

      // R2 select captured at frame start
      frame(8'hD4, 0, 0, 1, 2);
      mptr[1] = (mptr[1] + 4) & MASK;
      probe_all("R2 select latched at chip select");

      // constrained random frames
      for (int it = 0; it < 30; it++) begin
         int pick, sel, nw, ex;
         pick = $urandom_range(0, 6);
         sel  = $urandom_range(0, 3);
         nw   = $urandom_range(0, 3);
         ex   = ($urandom_range(0, 1) == 1) ? $urandom_range(1, 15) : 0;
         case (pick)
            0: rop = 8'hD0;
            1: rop = 8'hD2;
            2: rop = 8'hD4;
            3: rop = 8'h40;
            4: rop = 8'hC0;
            5: rop = 8'hC8;
            default: begin
               rop = 8'($urandom_range(0, 255));
               while (is_cmd(rop)) rop = 8'($urandom_range(0, 255));
            end
         endcase
         run(rop, nw, ex, sel);
         probe(sel, "R2 active pointer after random frame");
      end
      probe_all("R2 all pointers after random run");

      // final memory image, R7
      for (int i = 0; i < DEPTH; i++)
         chk(bmem[i] == mmem[i], "R7 memory image", bmem[i], mmem[i]);

      chk(spi_miso == 1'b0, "R1 miso idle at end", spi_miso, 0);
      finish_run();
   end

endmodule